// File: doc/BRIEF.md
# Load Result Width Converter

This block sits between the data return of a load path and the register write port. It receives one raw 64-bit datum per strobe, along with the width of the memory access, a flag marking a byte-reversed load variant, the processor endian mode, a destination element width, and a saturation control pair. It produces the element value at the destination width, ready to be placed into a register.

The conversion runs in a fixed sequence. First, the datum is cut down to the access width. Next, its bytes are reversed inside that width when the reversal condition holds. Last, the value is brought to the destination width in one of two ways. Plain mode zero-extends or truncates it. Saturating mode reads the value as signed or unsigned at the access width and clamps it to the range of the destination width.

The result sits in one output register, so it appears one clock after the strobe. A three-state controller sequences the output:

- `ST_IDLE`: nothing has been converted since reset.
- `ST_SHOW`: a fresh result is presented and the valid flag is high.
- `ST_KEEP`: the last result is held with valid low.

The transitions are:

- `take` (strobe seen, from any state) goes to `ST_SHOW`.
- `age` (no strobe while in `ST_SHOW`) goes to `ST_KEEP`.
- `rest` (no strobe in `ST_IDLE` or `ST_KEEP`) stays put.

Top module: `ldcv_unit`

## Requirements
- R1: While reset is active and after it is released, before any strobe, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is 1 in exactly the cycle that follows a cycle with `in_stb` high. Back-to-back strobes keep it high, and each such cycle carries the result of the preceding strobe.
- R3: With no strobe, `out_data` keeps its last value unchanged, whatever the other inputs do.
- R4: Bytes are reversed when `brev_insn` equals `le_mode` (the two flags XNOR'd gives 1). Otherwise the byte order is kept.
- R5: Only the low bytes of `in_data` inside the access width are used. Reversal swaps byte k with byte (n-1-k) for n bytes of access, and higher input bytes have no effect on the result.
- R6: With `sat_en`=0, the result is the access-width value zero-extended or truncated to the destination width. All bits of `out_data` above the destination width are 0.
- R7: With `sat_en`=1 and `sat_signed`=0, a value above the all-ones maximum of the destination width gives that maximum. Otherwise the value passes through zero-extended.
- R8: With `sat_en`=1 and `sat_signed`=1, the value is sign-extended from the access width and clamped between the most negative and most positive values of the destination width. It is written in two's complement at the destination width, with the bits above that width 0.
- R9: In saturating mode with a destination width at least the access width, the value is only extended: zero-extended for unsigned, sign-extended to the destination width for signed.
- R10: Width codes on `op_w` and `dst_w` are 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64.
- R11: With `sat_en`=0, `sat_signed` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Datum and controls are valid this cycle |
| in_data | input | 64 | Raw memory datum, access-width value in the low bytes |
| op_w | input | 2 | Access width code |
| brev_insn | input | 1 | Load is the byte-reversed variant |
| le_mode | input | 1 | Processor runs little-endian |
| dst_w | input | 2 | Destination element width code |
| sat_en | input | 1 | Saturating conversion enable |
| sat_signed | input | 1 | 1 signed, 0 unsigned saturation |
| out_valid | output | 1 | Fresh result present |
| out_data | output | 64 | Converted element, zero above destination width |

## Verification
A controller stuck in or skipping a state shows at `out_valid` one cycle after the strobe. The flag either fails to rise, stays high into a quiet cycle, or rises without a strobe. Each transaction checks both that cycle and the next one.

A corrupted data register shows in the quiet cycle that follows, since `out_data` must not move there. A wrong reversal or clamp path appears in the same cycle as the valid flag. The directed corners target the sign boundaries, where a fault would otherwise hide.

// File: rtl/ldcv_pkg.sv
package ldcv_pkg;
    localparam int DATUM_W = 64;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATUM_W / LANE_W;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2,
        WID_64 = 2'd3
    } wid_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOW = 2'd1,
        ST_KEEP = 2'd2
    } ctl_e;

    function automatic logic [DATUM_W-1:0] width_mask(input wid_e w);
        logic [DATUM_W-1:0] m;
        unique case (w)
            WID_8:   m = {{(DATUM_W-8){1'b0}},  {8{1'b1}}};
            WID_16:  m = {{(DATUM_W-16){1'b0}}, {16{1'b1}}};
            WID_32:  m = {{(DATUM_W-32){1'b0}}, {32{1'b1}}};
            default: m = {DATUM_W{1'b1}};
        endcase
        return m;
    endfunction
endpackage

// File: rtl/ldcv_byte_order.sv
module ldcv_byte_order
    import ldcv_pkg::*;
(
    input  logic [DATUM_W-1:0] raw,
    input  wid_e               acc_w,
    input  logic               brev_insn,
    input  logic               le_mode,
    output logic [DATUM_W-1:0] ordered
);
    logic [DATUM_W-1:0] clipped;
    logic [DATUM_W-1:0] swapped;
    logic               do_swap;

    assign clipped = raw & width_mask(acc_w);
    assign do_swap = ~(brev_insn ^ le_mode);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int S16 = (k < 2) ? (1 - k) : 0;
        localparam int S32 = (k < 4) ? (3 - k) : 0;
        localparam int S64 = LANES - 1 - k;
        always_comb begin
            unique case (acc_w)
                WID_8:   swapped[k*LANE_W +: LANE_W] = (k == 0) ? clipped[LANE_W-1:0] : '0;
                WID_16:  swapped[k*LANE_W +: LANE_W] = (k < 2) ? clipped[S16*LANE_W +: LANE_W] : '0;
                WID_32:  swapped[k*LANE_W +: LANE_W] = (k < 4) ? clipped[S32*LANE_W +: LANE_W] : '0;
                default: swapped[k*LANE_W +: LANE_W] = clipped[S64*LANE_W +: LANE_W];
            endcase
        end
    end

    assign ordered = do_swap ? swapped : clipped;

    always_comb begin
        // R5
        byte_mask_chk: assert ((ordered & ~width_mask(acc_w)) == '0);
    end
endmodule

// File: rtl/ldcv_width_fit.sv
module ldcv_width_fit
    import ldcv_pkg::*;
(
    input  logic [DATUM_W-1:0] val,
    input  wid_e               acc_w,
    input  wid_e               dst_w,
    input  logic               sat_en,
    input  logic               sat_signed,
    output logic [DATUM_W-1:0] fitted
);
    logic [DATUM_W-1:0]        dmask;
    logic [DATUM_W-1:0]        pos_lim;
    logic [DATUM_W-1:0]        neg_lim;
    logic signed [DATUM_W-1:0] sx;
    logic [DATUM_W-1:0]        s_clamp;
    logic [DATUM_W-1:0]        u_clamp;
    int unsigned               sh;

    assign dmask   = width_mask(dst_w);
    assign pos_lim = dmask >> 1;
    assign neg_lim = ~pos_lim;

    always_comb begin
        unique case (acc_w)
            WID_8:   sh = DATUM_W - 8;
            WID_16:  sh = DATUM_W - 16;
            WID_32:  sh = DATUM_W - 32;
            default: sh = 0;
        endcase
        sx = $signed(val << sh) >>> sh;
    end

    always_comb begin
        if (sx > $signed(pos_lim))      s_clamp = pos_lim;
        else if (sx < $signed(neg_lim)) s_clamp = neg_lim;
        else                            s_clamp = sx;
    end

    assign u_clamp = (val > dmask) ? dmask : val;

    always_comb begin
        if (!sat_en)         fitted = val & dmask;
        else if (sat_signed) fitted = s_clamp & dmask;
        else                 fitted = u_clamp;
    end

    always_comb begin
        // R6
        upper_clear_chk: assert ((fitted & ~dmask) == '0);
    end
endmodule

// File: rtl/ldcv_unit.sv
module ldcv_unit
    import ldcv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_stb,
    input  logic [63:0] in_data,
    input  logic [1:0]  op_w,
    input  logic        brev_insn,
    input  logic        le_mode,
    input  logic [1:0]  dst_w,
    input  logic        sat_en,
    input  logic        sat_signed,
    output logic        out_valid,
    output logic [63:0] out_data
);
    ctl_e               state_q;
    ctl_e               state_d;
    logic [DATUM_W-1:0] ordered;
    logic [DATUM_W-1:0] fitted;
    logic [DATUM_W-1:0] data_q;

    ldcv_byte_order u_order (
        .raw       (in_data),
        .acc_w     (wid_e'(op_w)),
        .brev_insn (brev_insn),
        .le_mode   (le_mode),
        .ordered   (ordered)
    );

    ldcv_width_fit u_fit (
        .val        (ordered),
        .acc_w      (wid_e'(op_w)),
        .dst_w      (wid_e'(dst_w)),
        .sat_en     (sat_en),
        .sat_signed (sat_signed),
        .fitted     (fitted)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_stb) state_d = ST_SHOW;
            ST_SHOW: state_d = in_stb ? ST_SHOW : ST_KEEP;
            ST_KEEP: if (in_stb) state_d = ST_SHOW;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (in_stb) data_q <= fitted;
    end

    assign out_valid = (state_q == ST_SHOW);
    assign out_data  = data_q;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stb |=> out_valid);
    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> !out_valid);
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> $stable(out_data));
    // R7
    usat_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && sat_en && !sat_signed && dst_w == 2'd0) |=> (out_data[63:8] == '0));
    // R6
    trunc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && !sat_en && dst_w == 2'd1) |=> (out_data[63:16] == '0));
endmodule

// File: tb/test_ldcv_unit.sv
module test_ldcv_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_stb = 1'b0;
    logic [63:0] in_data = '0;
    logic [1:0]  op_w = '0;
    logic        brev_insn = 1'b0;
    logic        le_mode = 1'b1;
    logic [1:0]  dst_w = '0;
    logic        sat_en = 1'b0;
    logic        sat_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    ldcv_unit i_ldcv_unit (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .in_data(in_data),
        .op_w(op_w), .brev_insn(brev_insn), .le_mode(le_mode), .dst_w(dst_w),
        .sat_en(sat_en), .sat_signed(sat_signed),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] ref_conv(input logic [63:0] d, input logic [1:0] op,
                                             input logic br, input logic le, input logic [1:0] dw,
                                             input logic sat, input logic sg);
        int ob = 8 << op;
        int db = 8 << dw;
        int nb = 1 << op;
        logic [63:0] om, dm, raw, r;
        longint sv, hi, lo;
        om = (ob == 64) ? '1 : ((64'd1 << ob) - 64'd1);
        dm = (db == 64) ? '1 : ((64'd1 << db) - 64'd1);
        raw = d & om;
        if (br == le) begin
            r = '0;
            for (int k = 0; k < nb; k++) r[8*k +: 8] = raw[8*(nb-1-k) +: 8];
            raw = r;
        end
        if (!sat) return raw & dm;
        if (sg) begin
            sv = $signed(raw << (64 - ob)) >>> (64 - ob);
            hi = longint'(dm >> 1);
            lo = -hi - 1;
            if (sv > hi) sv = hi;
            else if (sv < lo) sv = lo;
            return 64'(sv) & dm;
        end
        return (raw > dm) ? dm : raw;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic conv(input string req, input logic [63:0] d, input logic [1:0] op,
                        input logic br, input logic le, input logic [1:0] dw,
                        input logic sat, input logic sg, input logic [63:0] exp);
        in_data = d; op_w = op; brev_insn = br; le_mode = le; dst_w = dw;
        sat_en = sat; sat_signed = sg; in_stb = 1'b1;
        @(negedge clk);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_data, exp);
        in_stb = 1'b0;
        in_data = ~d; op_w = ~op; dst_w = ~dw; sat_en = ~sat;
        @(negedge clk);
        check("R2 valid drop", {63'd0, out_valid}, 64'd0);
        check("R3 hold", out_data, exp);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [1:0] op, dw;
        logic br, le, sat, sg;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 data in reset", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, out_valid}, 64'd0);
        check("R1 data after reset", out_data, 64'd0);

        // R4 / R5 / R10: byte order and access width
        conv("R5 no swap 32", 64'hAAAA_AAAA_1122_3344, 2'd2, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 64'h0000_0000_1122_3344);
        conv("R4 brev le swap", 64'hAAAA_AAAA_1122_3344, 2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 64'h0000_0000_4433_2211);
        conv("R4 be swap", 64'h0000_0000_1122_3344, 2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 64'h0000_0000_4433_2211);
        conv("R4 brev be keep", 64'h0000_0000_1122_3344, 2'd2, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 64'h0000_0000_1122_3344);
        conv("R5 swap 16", 64'hFFFF_FFFF_FFFF_1234, 2'd1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 64'h0000_0000_0000_3412);
        conv("R5 swap 64", 64'h0102_0304_0506_0708, 2'd3, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 64'h0807_0605_0403_0201);
        // R6 truncation
        conv("R6 trunc 8", 64'h1234_5678_9ABC_ABCD, 2'd3, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_00CD);
        conv("R6 zero ext", 64'hFFFF_FFFF_FFFF_FF80, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 64'h0000_0000_0000_0080);
        // R7 unsigned saturation
        conv("R7 clamp", 64'h0000_0000_0000_1234, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_00FF);
        conv("R7 pass", 64'h0000_0000_0000_0042, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_0042);
        conv("R7 edge", 64'h0000_0000_0000_00FF, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 64'h0000_0000_0000_00FF);
        // R8 signed saturation
        conv("R8 neg clamp", 64'h0000_0000_0000_8000, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_0080);
        conv("R8 pos clamp", 64'h0000_0000_0000_7FFF, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_007F);
        conv("R8 in range", 64'h0000_0000_0000_FF85, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_0085);
        conv("R8 edge -128", 64'h0000_0000_0000_FF80, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_0080);
        conv("R8 edge -129", 64'h0000_0000_0000_FF7F, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 64'h0000_0000_0000_0080);
        // R9 widening in saturating mode
        conv("R9 signed ext", 64'h0000_0000_0000_0080, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 64'h0000_0000_FFFF_FF80);
        conv("R9 unsigned ext", 64'h0000_0000_0000_0080, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 64'h0000_0000_0000_0080);
        conv("R9 signed 64", 64'h0000_0000_8000_0000, 2'd2, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 64'hFFFF_FFFF_8000_0000);
        // R11 sign select ignored without saturation
        conv("R11 ignore sign", 64'h0000_0000_0000_8000, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 64'h0000_0000_0000_0000);

        // R2 back-to-back strobes
        in_data = 64'h0000_0000_0000_00AB; op_w = 2'd0; brev_insn = 1'b0; le_mode = 1'b1;
        dst_w = 2'd3; sat_en = 1'b0; sat_signed = 1'b0; in_stb = 1'b1;
        @(negedge clk);
        check("R2 b2b first valid", {63'd0, out_valid}, 64'd1);
        check("R2 b2b first data", out_data, 64'h0000_0000_0000_00AB);
        in_data = 64'h0000_0000_0000_00CD;
        @(negedge clk);
        check("R2 b2b second valid", {63'd0, out_valid}, 64'd1);
        check("R2 b2b second data", out_data, 64'h0000_0000_0000_00CD);
        in_stb = 1'b0;
        @(negedge clk);
        check("R2 b2b drop", {63'd0, out_valid}, 64'd0);

        // random mix covering R4..R11
        for (int n = 0; n < 400; n++) begin
            d = {$urandom, $urandom};
            op = 2'($urandom); dw = 2'($urandom);
            br = 1'($urandom); le = 1'($urandom);
            sat = 1'($urandom); sg = 1'($urandom);
            if (n % 4 == 0) d[15:0] = (n % 8 == 0) ? 16'h8000 : 16'h7FFF;
            conv("R6-R9 random", d, op, br, le, dw, sat, sg, ref_conv(d, op, br, le, dw, sat, sg));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule